// File: doc/BRIEF.md
# Multi-Mode YUV 4:2:2 Output Formatter

This block takes a YUV 4:2:2 pixel stream (one luminance byte and one chrominance byte per pixel, with chroma alternating Cb and Cr) and puts it onto one or two 8-bit output ports. It also takes horizontal, vertical and active-video reference strobes and a field flag. The block runs on a clock at twice the pixel rate. A sample-enable input, high on every other cycle, marks the cycles in which a new pixel is taken in.

A 2-bit format input picks one of four output styles:

- **00:** a 16-bit stream on two ports, with separate sync outputs.
- **11:** an 8-bit Cb/Y/Cr/Y stream on port A, with separate sync outputs.
- **01:** an 8-bit stream with four-byte timing headers around every active line.
- **10:** an 8-bit stream with single-byte start and end codes.

In every 8-bit style, port B carries a programmable general-purpose byte. The format only takes effect when a new frame reaches the output, so a mode change never splits a frame.

A pixel-rate qualifier output is produced for single, double and half clock-speed modes. An output-enable input forces both ports to zero.

Top module: `vid_fmt_out`

## Requirements
- R1: During reset, and until the first pixel reaches the output, both ports and all sync outputs are 0 and the qualifier is low; the active format after reset is 00.
- R2: Format 00: a pixel taken at a sample-enable edge appears two sample edges later. Port A shows its Y byte and port B its C byte for both cycles of the pixel. The sync outputs show that pixel's horizontal, vertical and active flags.
- R3: Format 11: port A shows the C byte of the output pixel in the cycle after its sample edge and the Y byte in the next cycle, with no value changed. The sync outputs follow the output pixel.
- R4: Format 01: the two blanking pixels just before the first active pixel carry the bytes FF, 00, 00, XY (C slot first). The two blanking pixels just after the last active pixel carry the same pattern.
- R5: Format 01: the header byte XY is {1, F, V, H, V^H, F^H, F^V, F^V^H} from bit 7 down to bit 0. F is the field flag and V the vertical flag of the header pixel; H is 0 before active video and 1 after it.
- R6: Format 10: the C slot of the last blanking pixel before active video is FF, and the C slot of the first blanking pixel after active video is 00.
- R7: In formats 01 and 10 every data byte outside a header or code slot that equals 00 becomes 01, and one that equals FF becomes FE. Formats 00 and 11 pass bytes unchanged.
- R8: In formats 01 and 10 the three sync outputs are held at 0.
- R9: In formats 11, 01 and 10, port B equals the general-purpose input byte.
- R10: A new format value is adopted only in the cycle where the output pixel's vertical flag goes from 0 to 1. Until then the previous format stays in force.
- R11: With output enable low both ports read 0. The sync outputs are not affected.
- R12: The qualifier follows the speed input. For 00 (single) it is high in the cycle after each sample edge. For 01 (double) it is high in every cycle. For 10 (half) it is high after every second sample edge, starting with the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | Pixel sample strobe, high every other cycle |
| y_in | input | 8 | Luminance byte |
| c_in | input | 8 | Chrominance byte (Cb, Cr alternating) |
| href_in | input | 1 | Horizontal reference |
| vref_in | input | 1 | Vertical reference, high during vertical blanking |
| vact_in | input | 1 | Active video flag |
| field_in | input | 1 | Field flag |
| fmt_sel | input | 2 | Requested output format |
| spd_sel | input | 2 | Clock-speed mode for the qualifier |
| gp_val | input | 8 | Byte driven on port B in 8-bit formats |
| oe | input | 1 | Output enable for both ports |
| port_a | output | 8 | Output port A |
| port_b | output | 8 | Output port B |
| href_o | output | 1 | Separate horizontal reference |
| vref_o | output | 1 | Separate vertical reference |
| vact_o | output | 1 | Separate active flag |
| pix_qual | output | 1 | Pixel clock qualifier |

## Verification
A wrong entry in the pixel delay line shows at the ports within two sample edges. It appears as a misplaced or missing header, a byte from the wrong pixel, or a sync edge one pixel off. A wrong active-format register shows as soon as the next byte leaves, as the wrong port B source or sync gating, and it persists for a whole frame. For that reason every byte slot is compared against a model that is kept per pixel. A corrupted C/Y phase bit swaps the two bytes of a pixel in the very next cycle.

// File: rtl/vfo_pkg.sv
// Shared types for the YUV 4:2:2 output formatter.
// Assumes 8-bit samples and two-pixel timing headers.
package vfo_pkg;
    localparam int BYTE_W  = 8;
    localparam int HDR_PIX = 2;

    typedef enum logic [1:0] {
        FMT_SEP16 = 2'b00,
        FMT_656   = 2'b01,
        FMT_CODE  = 2'b10,
        FMT_SEP8  = 2'b11
    } ofmt_e;

    typedef enum logic [2:0] {
        K_DATA, K_SAV1, K_SAV2, K_EAV1, K_EAV2, K_SCODE, K_ECODE
    } kind_e;

    typedef struct packed {
        logic href;
        logic vref;
        logic act;
        logic fld;
    } ref_t;
endpackage

// File: rtl/vfo_pipe.sv
// Pixel delay line: holds LOOK pixels of lookahead ahead of the output
// pixel and LOOK pixels of active-flag history behind it.
// Assumes smp_en is high on every other clock cycle.
module vfo_pipe
    import vfo_pkg::*;
#(
    parameter int LOOK = HDR_PIX,
    parameter int BW   = BYTE_W
)
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    input  logic [BW-1:0] y_in,
    input  logic [BW-1:0] c_in,
    input  ref_t          ref_in,
    output logic [BW-1:0] o_y,
    output logic [BW-1:0] o_c,
    output ref_t          o_ref,
    output logic [LOOK-1:0] ahead_act,
    output logic [LOOK-1:0] past_act,
    output logic          sel_y,
    output logic          frame_start
);
    logic [BW-1:0] y_q [0:LOOK];
    logic [BW-1:0] c_q [0:LOOK];
    ref_t          r_q [0:LOOK];

    for (genvar s = 0; s <= LOOK; s++) begin : g_stg
        if (s == 0) begin : g_head
            // capture a new pixel on each sample edge
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    y_q[0] <= '0; c_q[0] <= '0; r_q[0] <= '0;
                end else if (smp_en) begin
                    y_q[0] <= y_in; c_q[0] <= c_in; r_q[0] <= ref_in;
                end
            end
        end else begin : g_tail
            // advance the delay line by one pixel
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    y_q[s] <= '0; c_q[s] <= '0; r_q[s] <= '0;
                end else if (smp_en) begin
                    y_q[s] <= y_q[s-1]; c_q[s] <= c_q[s-1]; r_q[s] <= r_q[s-1];
                end
            end
        end
    end

    for (genvar j = 0; j < LOOK; j++) begin : g_ahead
        assign ahead_act[j] = r_q[LOOK-1-j].act;
    end

    // remember the active flags of the last output pixels
    always_ff @(posedge clk) begin
        if (!rst_n)
            past_act <= '0;
        else if (smp_en)
            past_act <= {past_act[LOOK-2:0], r_q[LOOK].act};
    end

    // C byte in the cycle after a sample edge, Y byte in the next
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_y <= 1'b0;
        else
            sel_y <= !smp_en;
    end

    assign o_y         = y_q[LOOK];
    assign o_c         = c_q[LOOK];
    assign o_ref       = r_q[LOOK];
    assign frame_start = smp_en && r_q[LOOK-1].vref && !r_q[LOOK].vref;
endmodule

// File: rtl/vfo_hdr.sv
// Classifies the output pixel as data, a header half or a single code.
// The choice depends on the active flags around it. Also builds the XY byte.
// Assumes at least four blanking pixels between active runs.
module vfo_hdr
    import vfo_pkg::*;
(
    input  ofmt_e       fmt,
    input  ref_t        o_ref,
    input  logic [1:0]  ahead_act,
    input  logic [1:0]  past_act,
    output kind_e       kind,
    output logic [7:0]  xy
);
    logic hbit;

    // pick the slot kind; end-of-line markers take priority
    always_comb begin
        kind = K_DATA;
        if (!o_ref.act) begin
            if (fmt == FMT_656) begin
                if (past_act[0])                      kind = K_EAV1;
                else if (past_act[1])                 kind = K_EAV2;
                else if (ahead_act[0])                kind = K_SAV2;
                else if (ahead_act[1])                kind = K_SAV1;
            end else if (fmt == FMT_CODE) begin
                if (past_act[0])                      kind = K_ECODE;
                else if (ahead_act[0])                kind = K_SCODE;
            end
        end
    end

    // timing word with protection bits
    assign hbit = (kind == K_EAV2);
    assign xy = {1'b1, o_ref.fld, o_ref.vref, hbit,
                 o_ref.vref ^ hbit, o_ref.fld ^ hbit,
                 o_ref.fld ^ o_ref.vref, o_ref.fld ^ o_ref.vref ^ hbit};
endmodule

// File: rtl/vfo_mux.sv
// Port drivers: picks bytes for ports A and B by format and slot kind,
// clips reserved values in embedded formats, and gates with output enable.
module vfo_mux
    import vfo_pkg::*;
#(
    parameter int BW = BYTE_W
)
(
    input  ofmt_e         fmt,
    input  kind_e         kind,
    input  logic [7:0]    xy,
    input  logic          sel_y,
    input  logic [BW-1:0] o_y,
    input  logic [BW-1:0] o_c,
    input  ref_t          o_ref,
    input  logic [BW-1:0] gp,
    input  logic          oe,
    output logic [BW-1:0] port_a,
    output logic [BW-1:0] port_b,
    output logic          href_o,
    output logic          vref_o,
    output logic          vact_o
);
    localparam logic [BW-1:0] ALL0 = '0;
    localparam logic [BW-1:0] ALL1 = '1;
    localparam logic [BW-1:0] LOW1 = BW'(1);
    localparam logic [BW-1:0] HIGH1 = ALL1 - LOW1;

    logic          embed;
    logic [BW-1:0] cb, yb, a_pre, b_pre;

    function automatic logic [BW-1:0] clip(input logic [BW-1:0] v);
        if (v == ALL0)      return LOW1;
        else if (v == ALL1) return HIGH1;
        else                return v;
    endfunction

    assign embed = (fmt == FMT_656) || (fmt == FMT_CODE);

    // byte content of the two slots of the output pixel
    always_comb begin
        cb = embed ? clip(o_c) : o_c;
        yb = embed ? clip(o_y) : o_y;
        case (kind)
            K_SAV1, K_EAV1: begin cb = ALL1; yb = ALL0; end
            K_SAV2, K_EAV2: begin cb = ALL0; yb = BW'(xy); end
            K_SCODE:        cb = ALL1;
            K_ECODE:        cb = ALL0;
            default: ;
        endcase
    end

    // port routing by format
    always_comb begin
        if (fmt == FMT_SEP16) begin
            a_pre = o_y;
            b_pre = o_c;
        end else begin
            a_pre = sel_y ? yb : cb;
            b_pre = gp;
        end
    end

    assign port_a = oe ? a_pre : '0;
    assign port_b = oe ? b_pre : '0;
    assign href_o = !embed && o_ref.href;
    assign vref_o = !embed && o_ref.vref;
    assign vact_o = !embed && o_ref.act;
endmodule

// File: rtl/vfo_qual.sv
// Pixel clock qualifier for single, double and half clock-speed modes.
// Assumes smp_en marks pixel edges.
module vfo_qual (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_en,
    input  logic [1:0] spd,
    output logic       pix_qual
);
    logic stb_q, half_q;

    // track pixel edges and their parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            half_q <= 1'b0;
        end else begin
            stb_q <= smp_en;
            if (smp_en) half_q <= !half_q;
        end
    end

    // select the qualifier pattern
    always_comb begin
        case (spd)
            2'b01:   pix_qual = 1'b1;
            2'b10:   pix_qual = stb_q && half_q;
            default: pix_qual = stb_q;
        endcase
    end
endmodule

// File: rtl/vid_fmt_out.sv
// YUV 4:2:2 output formatter top. Holds the frame-aligned active format
// and connects the delay line, the header classifier, the port drivers
// and the qualifier. Assumes a clock at twice the pixel rate.
module vid_fmt_out
    import vfo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_en,
    input  logic [7:0] y_in,
    input  logic [7:0] c_in,
    input  logic       href_in,
    input  logic       vref_in,
    input  logic       vact_in,
    input  logic       field_in,
    input  logic [1:0] fmt_sel,
    input  logic [1:0] spd_sel,
    input  logic [7:0] gp_val,
    input  logic       oe,
    output logic [7:0] port_a,
    output logic [7:0] port_b,
    output logic       href_o,
    output logic       vref_o,
    output logic       vact_o,
    output logic       pix_qual
);
    ofmt_e       act_fmt;
    ref_t        in_ref, out_ref;
    logic [7:0]  o_y, o_c, xy;
    logic [HDR_PIX-1:0] ahead_act, past_act;
    logic        sel_y, frame_start;
    kind_e       kind;

    assign in_ref = '{href: href_in, vref: vref_in, act: vact_in, fld: field_in};

    // adopt a new format only when a frame begins at the output
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_fmt <= FMT_SEP16;
        else if (frame_start)
            act_fmt <= ofmt_e'(fmt_sel);
    end

    vfo_pipe #(.LOOK(HDR_PIX), .BW(BYTE_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
        .y_in(y_in), .c_in(c_in), .ref_in(in_ref),
        .o_y(o_y), .o_c(o_c), .o_ref(out_ref),
        .ahead_act(ahead_act), .past_act(past_act),
        .sel_y(sel_y), .frame_start(frame_start)
    );

    vfo_hdr u_hdr (
        .fmt(act_fmt), .o_ref(out_ref),
        .ahead_act(ahead_act), .past_act(past_act),
        .kind(kind), .xy(xy)
    );

    vfo_mux #(.BW(BYTE_W)) u_mux (
        .fmt(act_fmt), .kind(kind), .xy(xy), .sel_y(sel_y),
        .o_y(o_y), .o_c(o_c), .o_ref(out_ref), .gp(gp_val), .oe(oe),
        .port_a(port_a), .port_b(port_b),
        .href_o(href_o), .vref_o(vref_o), .vact_o(vact_o)
    );

    vfo_qual u_qual (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .spd(spd_sel),
        .pix_qual(pix_qual)
    );
endmodule

// File: rtl/vfo_chk.sv
// Property checker for the output formatter, bound to the top module.
module vfo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       oe,
    input logic [1:0] spd_sel,
    input logic [7:0] gp_val,
    input logic [7:0] port_a,
    input logic [7:0] port_b,
    input logic       href_o,
    input logic       vref_o,
    input logic       vact_o,
    input logic       pix_qual,
    input logic [1:0] act_fmt,
    input logic       out_vref
);
    // R11
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (port_a == 8'h00 && port_b == 8'h00));

    // R9
    gp_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && act_fmt != 2'b00) |-> port_b == gp_val);

    // R8
    embed_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fmt == 2'b01 || act_fmt == 2'b10) |-> (!href_o && !vref_o && !vact_o));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fmt != $past(act_fmt)) |-> (out_vref && !$past(out_vref)));

    // R12
    dbl_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_sel == 2'b01) |-> pix_qual);
endmodule

bind vid_fmt_out vfo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .oe(oe), .spd_sel(spd_sel), .gp_val(gp_val),
    .port_a(port_a), .port_b(port_b), .href_o(href_o), .vref_o(vref_o),
    .vact_o(vact_o), .pix_qual(pix_qual), .act_fmt(act_fmt),
    .out_vref(out_ref.vref)
);

// File: tb/sim_vid_fmt_out.sv
module sim_vid_fmt_out;
    localparam int HMAX  = 4096;
    localparam int NFRM  = 10;
    localparam int LINES = 5;
    localparam int VBL   = 2;
    localparam int LPIX  = 12;
    localparam int BLANK = 6;
    localparam int HW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_en = 1'b0;
    logic [7:0] y_in = '0, c_in = '0, gp_val = '0;
    logic href_in = 0, vref_in = 0, vact_in = 0, field_in = 0, oe = 1'b1;
    logic [1:0] fmt_sel = 2'b11, spd_sel = 2'b00;
    logic [7:0] port_a, port_b;
    logic href_o, vref_o, vact_o, pix_qual;

    int errs = 0, checks = 0;
    bit done = 0;

    // reference model state
    logic [7:0] hy [0:HMAX-1];
    logic [7:0] hc [0:HMAX-1];
    logic hh [0:HMAX-1];
    logic hv [0:HMAX-1];
    logic ha [0:HMAX-1];
    logic hf [0:HMAX-1];
    int np = 0;
    logic [1:0] mf = 2'b00;
    logic msel = 0, mstb = 0, mhalf = 0;

    always #2 clk = ~clk;

    vid_fmt_out u0 (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .y_in(y_in), .c_in(c_in),
        .href_in(href_in), .vref_in(vref_in), .vact_in(vact_in), .field_in(field_in),
        .fmt_sel(fmt_sel), .spd_sel(spd_sel), .gp_val(gp_val), .oe(oe),
        .port_a(port_a), .port_b(port_b), .href_o(href_o), .vref_o(vref_o),
        .vact_o(vact_o), .pix_qual(pix_qual)
    );

    function automatic logic [7:0] gy(int i); return (i < 0) ? 8'h00 : hy[i]; endfunction
    function automatic logic [7:0] gc(int i); return (i < 0) ? 8'h00 : hc[i]; endfunction
    function automatic logic gh(int i); return (i < 0) ? 1'b0 : hh[i]; endfunction
    function automatic logic gv(int i); return (i < 0) ? 1'b0 : hv[i]; endfunction
    function automatic logic ga(int i); return (i < 0) ? 1'b0 : ha[i]; endfunction
    function automatic logic gf(int i); return (i < 0) ? 1'b0 : hf[i]; endfunction

    function automatic logic [7:0] clipv(logic [7:0] v);
        if (v == 8'h00) return 8'h01;
        if (v == 8'hFF) return 8'hFE;
        return v;
    endfunction

    // record each sampled pixel and the frame-aligned format
    always @(posedge clk) begin
        if (!rst_n) begin
            np = 0; mf = 2'b00; msel = 0; mstb = 0; mhalf = 0;
        end else begin
            msel = !smp_en;
            mstb = smp_en;
            if (smp_en) begin
                hy[np] = y_in; hc[np] = c_in; hh[np] = href_in;
                hv[np] = vref_in; ha[np] = vact_in; hf[np] = field_in;
                np = np + 1;
                mhalf = !mhalf;
                if (gv(np-3) && !gv(np-4)) mf = fmt_sel;
            end
        end
    end

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic do_check();
        int o;
        logic [7:0] cb, yb, ea, eb, xy;
        logic f, v, h, emb, sep;
        string ta, tb_, ts;
        o = np - 3;
        cb = gc(o); yb = gy(o);
        emb = (mf == 2'b01) || (mf == 2'b10);
        sep = !emb;
        ta = (mf == 2'b00) ? "R2" : (mf == 2'b11) ? "R3" : (mf == 2'b01) ? "R7" : "R7";
        if (emb) begin cb = clipv(cb); yb = clipv(yb); end
        f = gf(o); v = gv(o);
        if (!ga(o)) begin
            if (mf == 2'b01) begin
                if (ga(o-1)) begin cb = 8'hFF; yb = 8'h00; ta = "R4"; end
                else if (ga(o-2)) begin
                    h = 1'b1; cb = 8'h00; ta = "R5";
                    yb = {1'b1, f, v, h, v^h, f^h, f^v, f^v^h};
                end else if (ga(o+1)) begin
                    h = 1'b0; cb = 8'h00; ta = "R5";
                    yb = {1'b1, f, v, h, v^h, f^h, f^v, f^v^h};
                end else if (ga(o+2)) begin cb = 8'hFF; yb = 8'h00; ta = "R4"; end
            end else if (mf == 2'b10) begin
                if (ga(o-1)) begin cb = 8'h00; ta = "R6"; end
                else if (ga(o+1)) begin cb = 8'hFF; ta = "R6"; end
            end
        end
        ea = (mf == 2'b00) ? gy(o) : (msel ? yb : cb);
        eb = (mf == 2'b00) ? gc(o) : gp_val;
        tb_ = (mf == 2'b00) ? "R2" : "R9";
        ts = emb ? "R8" : "R2";
        if (fmt_sel != mf) ta = "R10";
        if (!oe) begin ea = 8'h00; eb = 8'h00; ta = "R11"; tb_ = "R11"; end
        if (!rst_n || np < 3) begin ta = "R1"; tb_ = "R1"; ts = "R1"; end
        chk(ta, "port_a", port_a, ea);
        chk(tb_, "port_b", port_b, eb);
        chk(ts, "href", {7'b0, href_o}, {7'b0, sep && gh(o)});
        chk(ts, "vref", {7'b0, vref_o}, {7'b0, sep && gv(o)});
        chk(ts, "vact", {7'b0, vact_o}, {7'b0, sep && ga(o)});
        chk(rst_n ? "R12" : "R1", "pix_qual", {7'b0, pix_qual},
            {7'b0, (spd_sel == 2'b01) ? 1'b1 : (spd_sel == 2'b10) ? (mstb && mhalf) : mstb});
    endtask

    task automatic tick(bit do_chk);
        @(negedge clk);
        if (do_chk) do_check();
    endtask

    function automatic logic [1:0] cfg(int f);
        case (f % 10)
            0: return 2'b11; 1: return 2'b01; 2: return 2'b10; 3: return 2'b00;
            4: return 2'b01; 5: return 2'b11; 6: return 2'b10; 7: return 2'b01;
            8: return 2'b00; default: return 2'b10;
        endcase
    endfunction

    initial begin
        int k;
        k = 0;
        fmt_sel = cfg(0);
        tick(0); tick(0); tick(1); tick(1);
        rst_n = 1'b1;
        for (int f = 0; f < NFRM; f++) begin
            spd_sel = 2'(f % 3);
            gp_val = 8'(f * 37 + 5);
            for (int ln = 0; ln < LINES; ln++) begin
                if (ln == 2) fmt_sel = cfg(f + 1);
                oe = !(f == 6 && (ln == 1 || ln == 2));
                for (int px = 0; px < LPIX; px++) begin
                    vref_in = (ln < VBL);
                    href_in = (px < HW);
                    vact_in = (ln >= VBL) && (px >= BLANK);
                    field_in = f[0];
                    y_in = (k % 13 == 0) ? 8'hFF : (k % 7 == 0) ? 8'h00 : 8'(k * 53 + 17);
                    c_in = (k % 11 == 0) ? 8'h00 : (k % 9 == 0) ? 8'hFF : 8'(k * 29 + 200);
                    smp_en = 1'b1;
                    tick(1);
                    smp_en = 1'b0;
                    tick(1);
                    k++;
                end
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule